// File: doc/BRIEF.md
# Key-Protected Watchdog Reset Timer

This block is a watchdog counter behind a small single-cycle register bus. Its configuration cannot be changed by a stray store. Every write to a guarded register must come right after two key writes to two separate access registers. One unlock opens exactly one guarded write, and any other bus traffic in between closes it again.

Once armed, the counter advances on each cycle in which the `tick` input is high. When an enabled tick arrives while the count equals the programmed limit, the count returns to zero and a sticky event flag is set. If the reset-enable bit is set, a reset request is also driven for a fixed number of clock cycles. Software clears the flag and the counter through guarded writes. It can read the count at any time without unlocking.

Register map (word addresses on `bus_addr`):

| Address | Register |
|---|---|
| 0 | arm |
| 1 | limit |
| 2 | count, read-only |
| 3 | flag |
| 4 | zero |
| 5 | key A |
| 6 | key B |
| 7 | unused |

Addresses 0, 1, 3 and 4 are the guarded registers.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, arm reads 0, count reads 0, flag reads 0, limit reads all ones, and `wdog_rst` is low. Addresses 5, 6 and 7 always read 0.
- R2: Writing 0xBABA to address 5 and then 0xEB10 to address 6, on consecutive bus accesses, unlocks the block. The next bus access, if it is a write to a guarded address, takes effect at that clock edge.
- R3: A guarded write without a valid unlock leaves the register unchanged. One unlock authorises only one guarded write.
- R4: A wrong key value, the keys in the wrong order, or any other bus access (read or write) between the first key, the second key and the guarded write returns the unlock to idle. The guarded write that follows is then ignored.
- R5: While arm bit 0 is 1, the count rises by one at each clock edge where `tick` is high. While arm bit 0 is 0, the count holds.
- R6: An enabled tick while the count equals the limit (a match) sets the count to 0 and sets flag bit 0.
- R7: On a match with arm bit 1 set, `wdog_rst` goes high after that clock edge and stays high for RST_CYCLES (default 4) cycles. A new match reloads the pulse. `wdog_rst` never rises without such a match.
- R8: An unlocked write of 0 to the flag register clears the flag. An unlocked write of a nonzero value leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R9: An unlocked write of any value to address 4 sets the count to 0. This takes precedence over a tick in the same cycle, and no match is raised in that cycle.
- R10: `bus_rdata` shows the addressed register during any read access, in the same cycle and without unlock. The arm value sits in bits 1:0 and the flag in bit 0, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from address |
| tick | input | 1 | Count enable strobe |
| wdog_rst | output | 1 | Reset request pulse |

## Verification
Two pairs of functions can meet in one clock edge. The first pair is a guarded flag-clearing write and a match. The second pair is a guarded counter-zero write and an enabled tick. The bench provokes both by steering the count up to the limit and then issuing the unlocked write with `tick` held high in that same cycle. It judges the result by the flag read back afterwards (still set), by the count read back (zero), and by whether `wdog_rst` rose. The random phase reaches these collisions again by chance, and a bench-side model derived from the requirements judges every cycle.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_ARM   = 3'd0,
      RA_LIMIT = 3'd1,
      RA_COUNT = 3'd2,
      RA_FLAG  = 3'd3,
      RA_ZERO  = 3'd4,
      RA_KEY_A = 3'd5,
      RA_KEY_B = 3'd6,
      RA_SPARE = 3'd7
   } reg_addr_e;

   typedef enum logic [1:0] {
      UL_IDLE = 2'd0,
      UL_HALF = 2'd1,
      UL_OPEN = 2'd2
   } unlock_e;

   localparam logic [15:0] KEY_A_VAL = 16'hBABA;
   localparam logic [15:0] KEY_B_VAL = 16'hEB10;

   function automatic logic is_guarded(input logic [ADDR_W-1:0] a);
      return (a == RA_ARM) || (a == RA_LIMIT) || (a == RA_FLAG) || (a == RA_ZERO);
   endfunction

endpackage

// File: rtl/kwd_unlock.sv
module kwd_unlock
   import kwd_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              open
);

   localparam logic [DATA_W-1:0] KA = DATA_W'(KEY_A_VAL);
   localparam logic [DATA_W-1:0] KB = DATA_W'(KEY_B_VAL);

   unlock_e st_q, st_d;
   logic    first_ok, second_ok;

   always_comb begin
      first_ok  = we && (addr == RA_KEY_A) && (wdata == KA);
      second_ok = we && (addr == RA_KEY_B) && (wdata == KB);
      st_d      = st_q;
      if (acc) begin
         if (first_ok)
            st_d = UL_HALF;
         else if ((st_q == UL_HALF) && second_ok)
            st_d = UL_OPEN;
         else
            st_d = UL_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= UL_IDLE;
      else
         st_q <= st_d;
   end

   assign open = (st_q == UL_OPEN);

endmodule

// File: rtl/kwd_count.sv
module kwd_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             clear,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] count,
   output logic             match
);

   logic [CNT_W-1:0] cnt_q;
   logic             step, at_top;

   always_comb begin
      step   = run && tick;
      at_top = (cnt_q == limit);
      match  = step && at_top && !clear;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (step)
         cnt_q <= at_top ? '0 : cnt_q + 1'b1;
   end

   assign count = cnt_q;

endmodule

// File: rtl/kwd_stretch.sv
module kwd_stretch #(
   parameter int LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse
);

   localparam int PW = (LEN < 2) ? 1 : $clog2(LEN + 1);

   generate
      if (LEN == 1) begin : g_single
         logic p_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               p_q <= 1'b0;
            else
               p_q <= fire;
         end
         assign pulse = p_q;
      end else begin : g_multi
         logic [PW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               left_q <= '0;
            else if (fire)
               left_q <= PW'(LEN);
            else if (left_q != '0)
               left_q <= left_q - 1'b1;
         end
         assign pulse = (left_q != '0);
      end
   endgenerate

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
   import kwd_pkg::*;
#(
   parameter int               DATA_W     = 32,
   parameter int               CNT_W      = 16,
   parameter int               RST_CYCLES = 4,
   parameter logic [CNT_W-1:0] LIMIT_RST  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick,
   output logic              wdog_rst
);

   if (DATA_W < 16) begin : g_bad_data_w
      $error("keyed_wdog: DATA_W must hold a 16-bit key");
   end
   if ((CNT_W < 1) || (CNT_W > DATA_W)) begin : g_bad_cnt_w
      $error("keyed_wdog: CNT_W must lie in 1..DATA_W");
   end
   if (RST_CYCLES < 1) begin : g_bad_len
      $error("keyed_wdog: RST_CYCLES must be at least 1");
   end

   logic             ul_open;
   logic             guarded_wr;
   logic             arm_wr, limit_wr, flag_wr, zero_wr;
   logic [1:0]       arm_q;
   logic [CNT_W-1:0] limit_q;
   logic             flag_q;
   logic [CNT_W-1:0] count_w;
   logic             match_w;
   logic             fire_w;

   kwd_unlock #(.DATA_W(DATA_W)) u_unlock (
      .clk   (clk),
      .rst_n (rst_n),
      .acc   (bus_en),
      .we    (bus_we),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .open  (ul_open)
   );

   always_comb begin
      guarded_wr = bus_en && bus_we && ul_open && is_guarded(bus_addr);
      arm_wr     = guarded_wr && (bus_addr == RA_ARM);
      limit_wr   = guarded_wr && (bus_addr == RA_LIMIT);
      flag_wr    = guarded_wr && (bus_addr == RA_FLAG);
      zero_wr    = guarded_wr && (bus_addr == RA_ZERO);
   end

   kwd_count #(.CNT_W(CNT_W)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (arm_q[0]),
      .tick  (tick),
      .clear (zero_wr),
      .limit (limit_q),
      .count (count_w),
      .match (match_w)
   );

   assign fire_w = match_w && arm_q[1];

   kwd_stretch #(.LEN(RST_CYCLES)) u_stretch (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire_w),
      .pulse (wdog_rst)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q   <= '0;
         limit_q <= LIMIT_RST;
         flag_q  <= 1'b0;
      end else begin
         if (arm_wr)
            arm_q <= bus_wdata[1:0];
         if (limit_wr)
            limit_q <= bus_wdata[CNT_W-1:0];
         if (match_w)
            flag_q <= 1'b1;
         else if (flag_wr && (bus_wdata == '0))
            flag_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_en && !bus_we) begin
         unique case (reg_addr_e'(bus_addr))
            RA_ARM:   bus_rdata = DATA_W'(arm_q);
            RA_LIMIT: bus_rdata = DATA_W'(limit_q);
            RA_COUNT: bus_rdata = DATA_W'(count_w);
            RA_FLAG:  bus_rdata = DATA_W'(flag_q);
            RA_ZERO, RA_KEY_A, RA_KEY_B, RA_SPARE: bus_rdata = '0;
            default:  bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
   import kwd_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 16,
   parameter int RST_CYCLES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              wdog_rst,
   input logic [1:0]        arm,
   input logic [CNT_W-1:0]  count,
   input logic              flag,
   input logic              open,
   input logic              match,
   input logic              clear
);

   int run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= 0;
      else if (wdog_rst)
         run_q <= run_q + 1;
      else
         run_q <= 0;
   end

   // R2
   a_r2_open_needs_key_b: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open) |-> $past(bus_en && bus_we && (bus_addr == RA_KEY_B) &&
                            (bus_wdata == DATA_W'(KEY_B_VAL))));

   // R3
   a_r3_locked_arm_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && (bus_addr == RA_ARM) && !open) |=> $stable(arm));

   // R4
   a_r4_access_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (open && bus_en) |=> !open);

   // R5
   a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm[0] && !clear) |=> $stable(count));

   // R6
   a_r6_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> flag);

   // R7
   a_r7_rst_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdog_rst) |-> $past(match && arm[1]));

   // R7
   a_r7_rst_full_length: assert property (@(posedge clk) disable iff (!rst_n)
      (!wdog_rst && (run_q != 0)) |-> (run_q >= RST_CYCLES));

   // R9
   a_r9_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count == '0));

endmodule

bind keyed_wdog kwd_checker #(
   .DATA_W     (DATA_W),
   .CNT_W      (CNT_W),
   .RST_CYCLES (RST_CYCLES)
) u_kwd_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_en    (bus_en),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .wdog_rst  (wdog_rst),
   .arm       (arm_q),
   .count     (count_w),
   .flag      (flag_q),
   .open      (ul_open),
   .match     (match_w),
   .clear     (zero_wr)
);

// File: tb/keyed_wdog_test.sv
module keyed_wdog_test;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int CW = 16;
   localparam int RSTC = 4;
   localparam logic [31:0] KA = 32'h0000BABA;
   localparam logic [31:0] KB = 32'h0000EB10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_en = 1'b0;
   logic          bus_we = 1'b0;
   logic [2:0]    bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          tick = 1'b0;
   logic          wdog_rst;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // model of the requirements
   logic [1:0]    m_arm;
   logic [CW-1:0] m_limit;
   logic [CW-1:0] m_count;
   logic          m_flag;
   int            m_ul;
   int            m_left;

   always #(CLK_PERIOD/2) clk = ~clk;

   keyed_wdog #(.DATA_W(DW), .CNT_W(CW), .RST_CYCLES(RSTC)) uut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tick(tick), .wdog_rst(wdog_rst)
   );

   task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] model_read(input logic [2:0] a);
      case (a)
         3'd0: return DW'(m_arm);
         3'd1: return DW'(m_limit);
         3'd2: return DW'(m_count);
         3'd3: return DW'(m_flag);
         default: return '0;
      endcase
   endfunction

   function automatic string read_tag(input logic [2:0] a);
      case (a)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R10";
         3'd3: return "R6";
         default: return "R1";
      endcase
   endfunction

   // one bus cycle, starting just after a falling edge
   task automatic step(input bit en, input bit we, input logic [2:0] a,
                       input logic [DW-1:0] wd, input bit tk, input string tag);
      bit prot, clr, mt;
      logic [1:0] n_arm; logic [CW-1:0] n_lim, n_cnt; logic n_flag; int n_ul, n_left;
      bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd; tick = tk;
      #1;
      if (en && !we) check(bus_rdata, model_read(a), tag);
      prot = en && we && (m_ul == 2) && (a == 0 || a == 1 || a == 3 || a == 4);
      clr  = prot && (a == 4);
      mt   = m_arm[0] && tk && (m_count == m_limit) && !clr;
      n_arm = (prot && a == 0) ? wd[1:0] : m_arm;
      n_lim = (prot && a == 1) ? wd[CW-1:0] : m_limit;
      if (clr) n_cnt = '0;
      else if (m_arm[0] && tk) n_cnt = (m_count == m_limit) ? '0 : m_count + 1'b1;
      else n_cnt = m_count;
      if (mt) n_flag = 1'b1;
      else if (prot && a == 3 && wd == '0) n_flag = 1'b0;
      else n_flag = m_flag;
      n_left = (mt && m_arm[1]) ? RSTC : ((m_left > 0) ? m_left - 1 : 0);
      if (!en) n_ul = m_ul;
      else if (we && a == 5 && wd == KA) n_ul = 1;
      else if (m_ul == 1 && we && a == 6 && wd == KB) n_ul = 2;
      else n_ul = 0;
      @(posedge clk);
      m_arm = n_arm; m_limit = n_lim; m_count = n_cnt; m_flag = n_flag;
      m_ul = n_ul; m_left = n_left;
      @(negedge clk);
      bus_en = 1'b0; tick = 1'b0;
      check(DW'(wdog_rst), DW'(m_left != 0), "R7");
   endtask

   task automatic rd(input logic [2:0] a, input string tag);
      step(1, 0, a, '0, 0, tag);
   endtask
   task automatic wr(input logic [2:0] a, input logic [DW-1:0] d, input string tag);
      step(1, 1, a, d, 0, tag);
   endtask
   task automatic unlock();
      wr(3'd5, KA, "R2");
      wr(3'd6, KB, "R2");
   endtask
   task automatic idle(input bit tk);
      step(0, 0, 3'd0, '0, tk, "R5");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int highs;
      m_arm = '0; m_limit = '1; m_count = '0; m_flag = 1'b0; m_ul = 0; m_left = 0;
      void'($urandom(32'h1234_5eed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(DW'(wdog_rst), '0, "R1");
      for (int a = 0; a < 8; a++) rd(3'(a), "R1");

      // R2 unlocked write lands
      unlock();
      wr(3'd1, 32'h2, "R2");
      rd(3'd1, "R2");
      check(DW'(m_limit), 32'h2, "R2");

      // R3 no unlock, and single use
      wr(3'd1, 32'h7, "R3");
      rd(3'd1, "R3");
      unlock();
      wr(3'd1, 32'h3, "R3");
      wr(3'd1, 32'h9, "R3");
      rd(3'd1, "R3");

      // R4 wrong key, swapped order, intervening accesses
      wr(3'd5, 32'h1234, "R4"); wr(3'd6, KB, "R4"); wr(3'd1, 32'h5, "R4");
      wr(3'd6, KB, "R4"); wr(3'd5, KA, "R4"); wr(3'd1, 32'h5, "R4");
      wr(3'd5, KA, "R4"); rd(3'd2, "R4"); wr(3'd6, KB, "R4"); wr(3'd1, 32'h5, "R4");
      unlock(); rd(3'd0, "R4"); wr(3'd1, 32'h5, "R4");
      unlock(); wr(3'd7, 32'h1, "R4"); wr(3'd1, 32'h5, "R4");
      rd(3'd1, "R4");
      check(DW'(m_limit), 32'h3, "R4");

      // R5 counting and hold
      unlock(); wr(3'd0, 32'h1, "R5");
      idle(1); idle(0); idle(1);
      rd(3'd2, "R5");
      check(DW'(m_count), 32'h2, "R5");
      unlock(); wr(3'd0, 32'h0, "R5");
      idle(1); idle(1);
      rd(3'd2, "R5");

      // R6 match without reset enable
      unlock(); wr(3'd0, 32'h1, "R6");
      idle(1); idle(1);
      rd(3'd3, "R6");
      rd(3'd2, "R6");
      check(DW'(m_flag), 32'h1, "R6");

      // R8 nonzero write keeps flag, zero clears
      unlock(); wr(3'd3, 32'h5, "R8"); rd(3'd3, "R8");
      unlock(); wr(3'd3, 32'h0, "R8"); rd(3'd3, "R8");

      // R7 reset pulse length
      unlock(); wr(3'd0, 32'h3, "R7");
      while (m_count != m_limit) idle(1);
      idle(1);
      highs = (wdog_rst === 1'b1) ? 1 : 0;
      for (int i = 0; i < 8; i++) begin
         idle(0);
         if (wdog_rst === 1'b1) highs++;
      end
      check(DW'(highs), DW'(RSTC), "R7");

      // R9 zero write beats a tick in the same cycle
      idle(1);
      unlock();
      step(1, 1, 3'd4, 32'hFF, 1, "R9");
      rd(3'd2, "R9");
      check(DW'(m_count), 32'h0, "R9");
      unlock();
      while (m_count != m_limit) idle(1);
      step(1, 1, 3'd4, 32'h1, 1, "R9");
      rd(3'd3, "R9");

      // R8 flag clear collides with a match
      while (m_count != m_limit) idle(1);
      unlock();
      step(1, 1, 3'd3, 32'h0, 1, "R8");
      rd(3'd3, "R8");
      check(DW'(m_flag), 32'h1, "R8");

      // R10 count readable mid-run without unlock
      idle(1);
      rd(3'd2, "R10");

      // constrained random phase
      for (int n = 0; n < 4000; n++) begin
         int sel;
         logic [DW-1:0] d;
         logic [2:0] a;
         sel = $urandom % 16;
         case ($urandom % 8)
            0: d = 32'h0; 1: d = 32'h1; 2: d = 32'h3; 3: d = 32'h2;
            4: d = KA; 5: d = KB; 6: d = 32'h5; default: d = $urandom;
         endcase
         if (sel < 4) begin
            unlock();
            a = ($urandom % 2) ? 3'd1 : 3'((($urandom % 2) ? 0 : 3) + (($urandom % 3 == 0) ? 1 : 0));
            if (a == 3'd1) d = DW'($urandom % 6);
            step(1, 1, a, d, ($urandom % 3) == 0, "R2");
         end else begin
            a = 3'($urandom % 8);
            if (a == 3'd1) d = DW'($urandom % 6);
            step(($urandom % 3) != 0, $urandom % 2, a, d, ($urandom % 2) == 0, read_tag(a));
         end
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule